// File: doc/BRIEF.md
# Dual-Register Multi-Function Timer

This block is a timer/counter unit built around two 16-bit down-counters. Each counter reloads from its own reload register when it steps past zero. A two-bit mode field assigns the counters one of four jobs: a pulse-width output with programmable high and low times, time-stamping of edges on two input pins, two independent timers or event counters, or one event counter running beside one timer that also captures edges.

Software reaches the unit through a simple write strobe with an address and data, and reads through a combinational read port. Counting is paced by a one-cycle `tick` enable or by edges on the two external pins. Each pin is synchronized before its edge is detected, and the edge polarity is selectable. Four event flags are latched: two underflows and two captures. Each flag has its own mask bit, and one interrupt line reports any flag whose mask bit is set.

Top module: `mft_unit`

## Requirements
- R1: After reset, every register reads zero, `pwm_out` is 0, `flags` is 0 and `irq` is 0.
- R2: Each counter decrements by one per enabled count event. An event that finds the counter at 0 loads the reload value instead and sets that counter's underflow flag (flag bit 0 for counter 1, bit 1 for counter 2). A reload value N therefore gives one underflow every N+1 events.
- R3: The register map is: 0 control, 1 reload 1, 2 reload 2, 3 count 1, 4 count 2, 5 capture 1, 6 capture 2, 7 flags/mask. Writing address 3 or 4 loads that counter directly, and the load wins over a count event in the same cycle. Reload registers read back what was written.
- R4: Control bits are: mode in [1:0], run in [2], pin A falling-edge select in [3], pin B falling-edge select in [4], counter 1 counts pin A edges in [5], counter 2 counts pin B edges in [6]. In mode 0 with run set, `pwm_out` starts high. Counter 1 counts ticks only while the output is high and counter 2 counts ticks only while it is low. The output goes low on a counter 1 underflow and high on a counter 2 underflow, so it is high for reload1+1 ticks and low for reload2+1 ticks. Outside running mode 0, `pwm_out` is 0.
- R5: In mode 1, both counters count ticks. A selected edge on pin A copies counter 1 into capture 1 and sets flag bit 2. A selected edge on pin B copies counter 1 into capture 2 and sets flag bit 3.
- R6: In mode 2, each counter counts selected edges of its own pin when its control source bit is set, and counts ticks when that bit is clear.
- R7: In mode 3, counter 1 counts selected edges of pin A and counter 2 counts ticks. A selected edge on pin B copies counter 2 into capture 2 and sets flag bit 3.
- R8: Each pin passes through two synchronizing flip-flops before edge detection. Only the selected polarity acts, where 0 means rising and 1 means falling. A pin change made just after a clock edge affects the registers at the third following clock edge.
- R9: A write to address 7 clears each flag whose bit in wdata[3:0] is 1 and loads the mask from wdata[11:8]. A flag set in the same cycle as its clear stays set. The flags read at address 7 in bits [3:0], with the mask in bits [11:8].
- R10: `irq` is high exactly when some flag is set and its mask bit is 1.
- R11: With run clear, counters hold, no flag is set and no capture happens, whatever happens on the pins and on `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for timer counting |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pin_a | input | 1 | External input A, asynchronous |
| pin_b | input | 1 | External input B, asynchronous |
| pwm_out | output | 1 | Pulse-width output |
| flags | output | 4 | Event flags: underflow 1, underflow 2, capture A, capture B |
| irq | output | 1 | OR of the masked flags |

## Verification
The pulse output is driven once with a steady tick, which shows that the high and low lengths follow their own reload values. It is then driven with a random tick pattern, which shows that only the active half counts. Capture is tried with a rising edge on one pin and a falling edge on the other, ten cycles apart. The difference between the two captured values checks both the time stamps and the polarity select, and an opposite-polarity edge shows that the wrong polarity is ignored. Event counting is tried with pin pulses while the tick is held low, so that pin-driven counting is not confused with tick-driven counting. The same pulses are then repeated with run cleared, to show that nothing is disturbed.

// File: rtl/mft_pkg.sv
package mft_pkg;

    typedef enum logic [1:0] {
        MODE_PWM     = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_DUAL    = 2'd2,
        MODE_MIXED   = 2'd3
    } mft_mode_e;

    typedef struct packed {
        logic      src_b;
        logic      src_a;
        logic      fall_b;
        logic      fall_a;
        logic      run;
        mft_mode_e mode;
    } mft_ctrl_t;

    localparam int CTRL_BITS = $bits(mft_ctrl_t);
    localparam int NFLAG     = 4;
    localparam int MASK_LSB  = 8;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_RL1   = 3'd1;
    localparam logic [2:0] A_RL2   = 3'd2;
    localparam logic [2:0] A_CNT1  = 3'd3;
    localparam logic [2:0] A_CNT2  = 3'd4;
    localparam logic [2:0] A_CAP1  = 3'd5;
    localparam logic [2:0] A_CAP2  = 3'd6;
    localparam logic [2:0] A_FLAGS = 3'd7;

    localparam int F_UF1  = 0;
    localparam int F_UF2  = 1;
    localparam int F_CAPA = 2;
    localparam int F_CAPB = 3;

endpackage

// File: rtl/mft_edge_sync.sv
module mft_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LEN = STAGES + 1;

    typedef struct packed {
        logic [LEN-1:0] chain;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[LEN-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];
    assign fall = ~s_q.chain[STAGES-1] & s_q.chain[STAGES];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise) else $error("edge detector pulsed twice"); // R8

endmodule

// File: rtl/mft_downcnt.sv
module mft_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         uflow
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    at_zero;

    assign at_zero = (s_q.cnt == '0);
    assign uflow   = dec & ~load & at_zero;
    assign count   = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (load)         s_d.cnt = load_val;
        else if (dec)     s_d.cnt = at_zero ? reload : s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> count == $past(reload)) else $error("no reload"); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && count != '0) |=> count == $past(count) - 1'b1) else $error("bad step"); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val)) else $error("load lost"); // R3

endmodule

// File: rtl/mft_unit.sv
module mft_unit
    import mft_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         pin_a,
    input  logic         pin_b,
    output logic         pwm_out,
    output logic [3:0]   flags,
    output logic         irq
);
    localparam int NCNT = 2;

    typedef struct packed {
        mft_ctrl_t                  ctrl;
        logic [NCNT-1:0][W-1:0]     rl;
        logic [NCNT-1:0][W-1:0]     cap;
        logic [NFLAG-1:0]           flg;
        logic [NFLAG-1:0]           mask;
        logic                       level;
    } unit_st_t;

    unit_st_t s_d, s_q;

    logic [NCNT-1:0]         pin_in, rise, fall, ev, src_sel, fall_sel;
    logic [NCNT-1:0]         dec, load, uf;
    logic [NCNT-1:0][W-1:0]  cnt;
    logic                    run, tk, pwm_mode, cap_a, cap_b;
    logic [W-1:0]            cap_b_val;

    assign pin_in = {pin_b, pin_a};

    for (genvar i = 0; i < NCNT; i++) begin : g_chan
        mft_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_in[i]),
            .rise (rise[i]),
            .fall (fall[i])
        );
        mft_downcnt #(.W(W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .dec     (dec[i]),
            .load    (load[i]),
            .load_val(wdata),
            .reload  (s_q.rl[i]),
            .count   (cnt[i]),
            .uflow   (uf[i])
        );
    end

    // Count-event and capture decode per mode
    always_comb begin
        run      = s_q.ctrl.run;
        pwm_mode = run && (s_q.ctrl.mode == MODE_PWM);
        tk       = run & tick;
        src_sel  = {s_q.ctrl.src_b, s_q.ctrl.src_a};
        fall_sel = {s_q.ctrl.fall_b, s_q.ctrl.fall_a};
        for (int i = 0; i < NCNT; i++) begin
            ev[i]   = run & (fall_sel[i] ? fall[i] : rise[i]);
            load[i] = wr_en && (addr == A_CNT1 + 3'(i));
        end
        dec = '0;
        unique case (s_q.ctrl.mode)
            MODE_PWM:     dec = {tk & ~s_q.level, tk & s_q.level};
            MODE_CAPTURE: dec = {tk, tk};
            MODE_DUAL: begin
                for (int i = 0; i < NCNT; i++) dec[i] = src_sel[i] ? ev[i] : tk;
            end
            MODE_MIXED:   dec = {tk, ev[0]};
            default:      dec = '0;
        endcase
        cap_a     = (s_q.ctrl.mode == MODE_CAPTURE) & ev[0];
        cap_b     = ((s_q.ctrl.mode == MODE_CAPTURE) | (s_q.ctrl.mode == MODE_MIXED)) & ev[1];
        cap_b_val = (s_q.ctrl.mode == MODE_MIXED) ? cnt[1] : cnt[0];
    end

    // Next-state of the register file
    always_comb begin
        logic [NFLAG-1:0] set_v, clr_v;
        s_d   = s_q;
        clr_v = '0;
        if (wr_en) begin
            unique case (addr)
                A_CTRL:  s_d.ctrl    = mft_ctrl_t'(wdata[CTRL_BITS-1:0]);
                A_RL1:   s_d.rl[0]   = wdata;
                A_RL2:   s_d.rl[1]   = wdata;
                A_FLAGS: begin
                    clr_v      = wdata[NFLAG-1:0];
                    s_d.mask   = wdata[MASK_LSB +: NFLAG];
                end
                default: ;
            endcase
        end
        if (cap_a) s_d.cap[0] = cnt[0];
        if (cap_b) s_d.cap[1] = cap_b_val;
        set_v         = '0;
        set_v[F_UF1]  = uf[0];
        set_v[F_UF2]  = uf[1];
        set_v[F_CAPA] = cap_a;
        set_v[F_CAPB] = cap_b;
        s_d.flg       = (s_q.flg & ~clr_v) | set_v;
        if (!pwm_mode)   s_d.level = 1'b1;
        else if (uf[0])  s_d.level = 1'b0;
        else if (uf[1])  s_d.level = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.level <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata[CTRL_BITS-1:0] = s_q.ctrl;
            A_RL1:   rdata = s_q.rl[0];
            A_RL2:   rdata = s_q.rl[1];
            A_CNT1:  rdata = cnt[0];
            A_CNT2:  rdata = cnt[1];
            A_CAP1:  rdata = s_q.cap[0];
            A_CAP2:  rdata = s_q.cap[1];
            A_FLAGS: begin
                rdata[NFLAG-1:0]          = s_q.flg;
                rdata[MASK_LSB +: NFLAG]  = s_q.mask;
            end
            default: rdata = '0;
        endcase
    end

    assign pwm_out = pwm_mode & s_q.level;
    assign flags   = s_q.flg;
    assign irq     = |(s_q.flg & s_q.mask);

    AST_PWM_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && uf[0] && !wr_en) |=> !pwm_out) else $error("pwm did not fall"); // R4
    AST_CAPA_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.mode == MODE_CAPTURE && ev[0]) |=> (flags[F_CAPA] && s_q.cap[0] == $past(cnt[0]))) else $error("capture lost"); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> flags == $past(flags)) else $error("flag moved while stopped"); // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (uf[0] && wr_en && addr == A_FLAGS && wdata[F_UF1]) |=> flags[F_UF1]) else $error("set lost to clear"); // R9
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_q.mask != '0)) else $error("irq without mask"); // R10

endmodule

// File: tb/mft_unit_test.sv
`timescale 1ns/1ps
module mft_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, wr_en = 1'b0, pin_a = 1'b0, pin_b = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        pwm_out, irq;
    logic [3:0]  flags;

    int    checks = 0, failures = 0, cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    mft_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b),
        .pwm_out(pwm_out), .flags(flags), .irq(irq)
    );

    // Behavioural reference model
    logic [6:0]  m_ctrl;
    int          m_rl1, m_rl2, m_c1, m_c2, m_cap1, m_cap2;
    logic [3:0]  m_flags, m_mask;
    logic        m_lvl;
    logic [2:0]  ha, hb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_rl1 = 0; m_rl2 = 0; m_c1 = 0; m_c2 = 0;
            m_cap1 = 0; m_cap2 = 0; m_flags = '0; m_mask = '0; m_lvl = 1'b1;
            ha = '0; hb = '0;
        end else begin
            automatic bit run  = m_ctrl[2];
            automatic int mode = int'(m_ctrl[1:0]);
            automatic bit ea   = run && (m_ctrl[3] ? (!ha[1] && ha[2]) : (ha[1] && !ha[2]));
            automatic bit eb   = run && (m_ctrl[4] ? (!hb[1] && hb[2]) : (hb[1] && !hb[2]));
            automatic bit t    = run && tick;
            automatic bit d1 = 0, d2 = 0, u1, u2, ca = 0, cb = 0;
            automatic logic [3:0] clr = '0;
            automatic int old_c1 = m_c1, old_c2 = m_c2;
            case (mode)
                0: begin d1 = t && m_lvl; d2 = t && !m_lvl; end
                1: begin d1 = t; d2 = t; ca = ea; cb = eb; end
                2: begin d1 = m_ctrl[5] ? ea : t; d2 = m_ctrl[6] ? eb : t; end
                default: begin d1 = ea; d2 = t; cb = eb; end
            endcase
            u1 = d1 && m_c1 == 0 && !(wr_en && addr == 3);
            u2 = d2 && m_c2 == 0 && !(wr_en && addr == 4);
            if (wr_en && addr == 3) m_c1 = wdata;
            else if (d1) m_c1 = (m_c1 == 0) ? m_rl1 : m_c1 - 1;
            if (wr_en && addr == 4) m_c2 = wdata;
            else if (d2) m_c2 = (m_c2 == 0) ? m_rl2 : m_c2 - 1;
            if (ca) m_cap1 = old_c1;
            if (cb) m_cap2 = (mode == 3) ? old_c2 : old_c1;
            if (!(run && mode == 0)) m_lvl = 1'b1;
            else if (u1) m_lvl = 1'b0;
            else if (u2) m_lvl = 1'b1;
            if (wr_en) begin
                case (addr)
                    3'd0: m_ctrl = wdata[6:0];
                    3'd1: m_rl1 = wdata;
                    3'd2: m_rl2 = wdata;
                    3'd7: begin clr = wdata[3:0]; m_mask = wdata[11:8]; end
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clr) | {cb, ca, u2, u1};
            ha = {ha[1:0], pin_a};
            hb = {hb[1:0], pin_b};
        end
    end

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {9'd0, m_ctrl};
            3'd1: return 16'(m_rl1);
            3'd2: return 16'(m_rl2);
            3'd3: return 16'(m_c1);
            3'd4: return 16'(m_c2);
            3'd5: return 16'(m_cap1);
            3'd6: return 16'(m_cap2);
            default: return {4'd0, m_mask, 4'd0, m_flags};
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic logic        e_pwm = (m_ctrl[2] && m_ctrl[1:0] == 2'd0) ? m_lvl : 1'b0;
            automatic logic        e_irq = |(m_flags & m_mask);
            automatic logic [15:0] e_rd  = model_read(addr);
            checks++;
            if (pwm_out !== e_pwm || irq !== e_irq || flags !== m_flags || rdata !== e_rd) begin
                failures++;
                $display("FAIL %s cycle %0d: pwm=%b irq=%b flags=%h rdata=%h expected pwm=%b irq=%b flags=%h rdata=%h",
                         cur_req, cycles, pwm_out, irq, flags, rdata, e_pwm, e_irq, m_flags, e_rd);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic pulse_a(input int n);
        for (int k = 0; k < n; k++) begin
            pin_a = 1'b1; step(2); pin_a = 1'b0; step(2);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] v, v2, c1s, c2s, fls;
        int hi, lo;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        cur_req = "R1";
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 0);
        end
        check("R1 pwm_out", pwm_out, 0);
        check("R1 irq", irq, 0);

        // R3 register access and direct load
        cur_req = "R3";
        wr(3'd1, 16'h1234); rd(3'd1, v); check("R3 reload1 readback", v, 16'h1234);
        wr(3'd3, 16'd7);    rd(3'd3, v); check("R3 count1 load", v, 7);

        // R4 pulse output
        cur_req = "R4";
        tick = 1'b1;
        wr(3'd1, 16'd2); wr(3'd2, 16'd4);
        wr(3'd3, 16'd2); wr(3'd4, 16'd4);
        wr(3'd0, 16'h0004);
        hi = 0; lo = 0;
        @(negedge clk);
        while (pwm_out && hi < 50) begin hi++; @(negedge clk); end
        while (!pwm_out && lo < 50) begin lo++; @(negedge clk); end
        check("R4 high length", hi, 3);
        check("R4 low length", lo, 5);
        for (int k = 0; k < 80; k++) begin
            @(posedge clk); #1; tick = 1'($urandom % 2);
        end
        tick = 1'b1;
        wr(3'd0, 16'h0000);
        @(negedge clk);
        check("R4 output low when stopped", pwm_out, 0);

        // R9 / R10 flags and mask
        cur_req = "R9";
        rd(3'd7, v); check("R9 underflow flags latched", v[1:0], 2'b11);
        cur_req = "R10";
        check("R10 irq masked off", irq, 0);
        wr(3'd7, 16'h0100); @(negedge clk);
        check("R10 irq with mask", irq, 1);
        cur_req = "R9";
        wr(3'd7, 16'h0103); rd(3'd7, v);
        check("R9 w1c clears flags", v, 16'h0100);
        check("R10 irq after clear", irq, 0);

        // R5 dual capture
        cur_req = "R5";
        pin_b = 1'b1;
        wr(3'd1, 16'hFFFF); wr(3'd3, 16'd1000);
        wr(3'd0, 16'h0015);
        step(3);
        pin_a = 1'b1; step(10);
        pin_b = 1'b0; step(6);
        rd(3'd5, v); rd(3'd6, v2);
        check("R5 capture spacing", v - v2, 10);
        check("R5 capture flags", flags[3:2], 2'b11);

        // R8 polarity and latency
        cur_req = "R8";
        wr(3'd7, 16'h000F);
        pin_a = 1'b0; step(6);
        check("R8 wrong polarity ignored", flags[2], 0);
        @(posedge clk); #1; pin_a = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R8 no capture before third edge", flags[2], 0);
        @(posedge clk); @(negedge clk);
        check("R8 capture at third edge", flags[2], 1);
        step(1); pin_a = 1'b0; step(4);

        // R2 period
        cur_req = "R2";
        tick = 1'b0;
        wr(3'd0, 16'h0002); wr(3'd1, 16'd3); wr(3'd3, 16'd3); wr(3'd7, 16'h000F);
        wr(3'd0, 16'h0006);
        tick = 1'b1; step(3); tick = 1'b0;
        rd(3'd3, v);
        check("R2 count at zero", v, 0);
        check("R2 no underflow yet", flags[0], 0);
        @(posedge clk); #1; tick = 1'b1; step(1); tick = 1'b0;
        rd(3'd3, v);
        check("R2 reload on underflow", v, 3);
        check("R2 underflow flag", flags[0], 1);

        // R3 load beats decrement
        cur_req = "R3";
        tick = 1'b1;
        wr(3'd3, 16'h0055);
        @(negedge clk);
        check("R3 load wins over count", rdata, 16'h0055);

        // R6 independent timers, event-driven counter 1
        cur_req = "R6";
        tick = 1'b0;
        wr(3'd0, 16'h0022); wr(3'd1, 16'd5); wr(3'd3, 16'd5); wr(3'd7, 16'h000F);
        wr(3'd0, 16'h0026);
        pulse_a(5); step(2);
        rd(3'd3, v); check("R6 counts pin edges", v, 0);
        pulse_a(1); step(2);
        rd(3'd3, v); check("R6 reload after events", v, 5);
        check("R6 event underflow flag", flags[0], 1);

        // R7 mixed mode
        cur_req = "R7";
        tick = 1'b1;
        wr(3'd0, 16'h0003); wr(3'd3, 16'd10); wr(3'd4, 16'd500); wr(3'd7, 16'h000F);
        wr(3'd0, 16'h0007);
        pulse_a(3); step(2);
        rd(3'd3, v); check("R7 event counter", v, 7);
        pin_b = 1'b1; step(5);
        check("R7 capture flag", flags[3], 1);
        check("R7 no pin A capture", flags[2], 0);
        pin_b = 1'b0;

        // R11 stopped
        cur_req = "R11";
        wr(3'd0, 16'h0062);
        step(4);
        rd(3'd3, c1s); rd(3'd4, c2s); rd(3'd7, fls);
        pulse_a(2); pin_b = 1'b1; step(10); pin_b = 1'b0; step(4);
        rd(3'd3, v); check("R11 counter1 holds", v, c1s);
        rd(3'd4, v); check("R11 counter2 holds", v, c2s);
        rd(3'd7, v); check("R11 flags hold", v, fls);

        step(3);
        finish_run();
    end
endmodule